// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This block sits between a core's load/store stage and a data memory that is 32 bits wide and addressed by word. For each request it adds a sign-extended 16-bit displacement to a base value to form a byte address. It also checks that word accesses are aligned. It then drives the memory's word address, four byte write enables and the write word with the data placed in the correct lane. Byte numbering is big-endian, so byte offset 0 of a word is bits 31:24.

The memory is expected to return read data on the clock edge after a read request. The unit registers the lane and size of each accepted load. In the following cycle it returns either the whole word or the addressed byte, sign-extended to 32 bits. A word access whose address is not a multiple of four is flagged in the same cycle and never reaches the memory. Byte accesses are never flagged.

Top module: `be_lane_unit`

## Requirements
- R1: The byte address is `base` plus `offset` sign-extended to 32 bits, and `mem_addr` is that address with its two low bits dropped. This holds in every cycle.
- R2: An aligned word store drives `mem_we` = 4'b1111 and `mem_wdata` = `st_data`.
- R3: A byte store drives exactly one enable. Byte offset 0 selects `mem_we[3]` (bits 31:24), 1 selects `mem_we[2]`, 2 selects `mem_we[1]` and 3 selects `mem_we[0]`. `mem_wdata` carries `st_data[7:0]` copied into all four lanes, and the other bytes of the memory word are left unchanged.
- R4: A valid word access whose address bits 1:0 are not zero raises `misalign` in the same cycle. That access drives `mem_req` low and `mem_we` to zero, so memory is left unchanged. Byte accesses never raise `misalign`.
- R5: A valid load that is not misaligned drives `mem_req` high and `mem_we` to zero.
- R6: `ld_valid` is high in the cycle after an accepted load, and only then. It stays low after stores, idle cycles and misaligned accesses.
- R7: A word load returns the memory word unchanged on `ld_data`.
- R8: A byte load returns the addressed big-endian byte in bits 7:0 of `ld_data`, with bit 7 of that byte copied into bits 31:8.
- R9: During and after synchronous active-low reset `ld_valid` is low. In a cycle with `req_valid` low, `mem_req`, `mem_we` and `misalign` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_data | input | 32 | Store source register value |
| mem_addr | output | 30 | Memory word address |
| mem_req | output | 1 | Memory access enable |
| mem_we | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed write word |
| misalign | output | 1 | Unaligned word access flag |
| mem_rdata | input | 32 | Memory read word, one cycle after request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
Two functions can fall in the same cycle. One is the return of a load issued in the previous cycle. The other is the issue of a new request, which can be a store into the word that was just read, or a misaligned access. The bench provokes this by issuing requests back to back with no idle cycles. It then checks two things in the same cycle. The returned `ld_data` must match the reference memory as it was when the load issued. The new request's enables and data must match its own decode. Later loads then confirm whether each store, including a suppressed misaligned one, changed the memory or left it alone.

// File: rtl/be_lane_pkg.sv
// Shared sizing for the big-endian lane unit.
// Assumes byte-granular addressing and a power-of-two byte count per word.
package be_lane_pkg;
    localparam int unsigned BYTE_W = 8;

    // Lane index counted from the most significant byte (big-endian).
    function automatic int unsigned be_lane_to_bit(input int unsigned lane,
                                                   input int unsigned nbytes);
        return (nbytes - 1 - lane) * BYTE_W;
    endfunction
endpackage

// File: rtl/be_ea_gen.sv
// Effective address generator.
// Adds a sign-extended displacement to a base value and flags word
// accesses whose low address bits are not zero. Purely combinational.
module be_ea_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned LANE_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_word,
    output logic [ADDR_W-1:0] ea,
    output logic              unaligned
);
    localparam int unsigned EXT_W = ADDR_W - OFF_W;

    // Sum of base and sign-extended displacement; alignment test on words.
    always_comb begin
        ea        = base + {{EXT_W{offset[OFF_W-1]}}, offset};
        unaligned = is_word && (ea[LANE_W-1:0] != '0);
    end
endmodule

// File: rtl/be_store_lane.sv
// Store lane placement.
// Produces big-endian byte enables and the write word; a byte store
// replicates the low source byte into every lane. Assumes 'active' is
// already gated by validity, store type and alignment.
module be_store_lane #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              is_word,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] st_data,
    output logic [DATA_W/8-1:0] we,
    output logic [DATA_W-1:0] wdata
);
    import be_lane_pkg::*;
    localparam int unsigned NB = DATA_W / BYTE_W;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        localparam int unsigned ADDR_LANE = NB - 1 - b;
        // Enable this byte for words, or when the address names it.
        always_comb begin
            we[b] = active && (is_word || (lane == LANE_W'(ADDR_LANE)));
            wdata[b*BYTE_W +: BYTE_W] = is_word ? st_data[b*BYTE_W +: BYTE_W]
                                                : st_data[BYTE_W-1:0];
        end
    end

    // R3
    byte_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !is_word) |-> ($countones(we) == 1));
    // R2
    word_we_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_word) |-> (&we));
endmodule

// File: rtl/be_load_lane.sv
// Load return path.
// Registers the lane and size of an accepted load, then selects and
// sign-extends the addressed byte from the word the memory returns one
// cycle later. Assumes a fixed one-cycle memory read latency.
module be_load_lane #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              is_word,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    import be_lane_pkg::*;
    localparam int unsigned NB = DATA_W / BYTE_W;

    logic              word_q;
    logic [LANE_W-1:0] lane_q;
    logic [BYTE_W-1:0] byte_sel;

    // Capture the shape of the load in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            word_q   <= 1'b0;
            lane_q   <= '0;
        end else begin
            ld_valid <= issue;
            word_q   <= is_word;
            lane_q   <= lane;
        end
    end

    // Pick the big-endian byte and widen it with its sign.
    always_comb begin
        byte_sel = '0;
        for (int k = 0; k < NB; k++) begin
            if (lane_q == LANE_W'(k))
                byte_sel = rdata[be_lane_to_bit(k, NB) +: BYTE_W];
        end
        ld_data = word_q ? rdata : {{(DATA_W-BYTE_W){byte_sel[BYTE_W-1]}}, byte_sel};
    end

    // R6
    ld_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(issue));
endmodule

// File: rtl/be_lane_unit.sv
// Big-endian load/store byte lane unit (top).
// Joins address generation, store lane placement and load extraction.
// Assumes one request per cycle and a memory with one-cycle read latency.
module be_lane_unit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_store,
    input  logic                        req_byte,
    input  logic [ADDR_W-1:0]           base,
    input  logic [OFF_W-1:0]            offset,
    input  logic [DATA_W-1:0]           st_data,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic                        mem_req,
    output logic [DATA_W/8-1:0]         mem_we,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic                        misalign,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        ld_valid,
    output logic [DATA_W-1:0]           ld_data
);
    localparam int unsigned NB     = DATA_W / 8;
    localparam int unsigned LANE_W = $clog2(NB);

    logic [ADDR_W-1:0] ea;
    logic              unaligned;
    logic              st_active;
    logic              ld_issue;

    be_ea_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_ea (
        .base(base), .offset(offset), .is_word(!req_byte),
        .ea(ea), .unaligned(unaligned)
    );

    // Qualify the request against validity and alignment.
    always_comb begin
        misalign  = req_valid && unaligned;
        mem_req   = req_valid && !unaligned;
        st_active = mem_req && req_store;
        ld_issue  = mem_req && !req_store;
        mem_addr  = ea[ADDR_W-1:LANE_W];
    end

    be_store_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
        .clk(clk), .rst_n(rst_n), .active(st_active), .is_word(!req_byte),
        .lane(ea[LANE_W-1:0]), .st_data(st_data),
        .we(mem_we), .wdata(mem_wdata)
    );

    be_load_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ld (
        .clk(clk), .rst_n(rst_n), .issue(ld_issue), .is_word(!req_byte),
        .lane(ea[LANE_W-1:0]), .rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // R4
    misalign_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_req && mem_we == '0));
    // R5
    load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |-> (mem_we == '0));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_req && !misalign && mem_we == '0));
    // R4
    byte_never_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_byte) |-> !misalign);
endmodule

// File: tb/sim_be_lane_unit.sv
module sim_be_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_byte = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] st_data = '0;
    logic [29:0] mem_addr;
    logic        mem_req;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        misalign;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;

    int vectors = 0;
    int fails   = 0;

    logic [31:0] ram [16];
    logic [7:0]  refmem [64];
    logic        pend_v = 1'b0;
    logic [31:0] pend_d = '0;

    always #5 clk = ~clk;

    be_lane_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_byte(req_byte), .base(base), .offset(offset), .st_data(st_data),
        .mem_addr(mem_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .misalign(misalign), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // Behavioural word RAM: one-cycle read, per-byte write.
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= ram[mem_addr[3:0]];
        for (int b = 0; b < 4; b++)
            if (mem_we[b]) ram[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare against the reference, update the model.
    task automatic step(input logic v, input logic st, input logic by,
                        input logic [31:0] b, input logic [15:0] o,
                        input logic [31:0] d);
        logic [31:0] e, exp_wd, word;
        logic [3:0]  exp_we;
        logic        exp_mis, exp_req;
        @(negedge clk);
        req_valid = v; req_store = st; req_byte = by;
        base = b; offset = o; st_data = d;
        #4;
        e       = b + {{16{o[15]}}, o};
        exp_mis = v && !by && (e[1:0] != 2'b00);
        exp_req = v && !exp_mis;
        exp_we  = '0;
        if (exp_req && st) exp_we = by ? (4'b1000 >> e[1:0]) : 4'hF;
        exp_wd  = by ? {4{d[7:0]}} : d;
        chk(mem_addr == e[31:2], "R1 mem_addr", {2'b0, mem_addr}, {2'b0, e[31:2]});
        chk(misalign == exp_mis, "R4 misalign", {31'b0, misalign}, {31'b0, exp_mis});
        chk(mem_req == exp_req, "R5/R9 mem_req", {31'b0, mem_req}, {31'b0, exp_req});
        chk(mem_we == exp_we, by ? "R3 mem_we" : "R2 mem_we", {28'b0, mem_we}, {28'b0, exp_we});
        if (exp_we != 0)
            chk(mem_wdata == exp_wd, by ? "R3 mem_wdata" : "R2 mem_wdata", mem_wdata, exp_wd);
        chk(ld_valid == pend_v, "R6 ld_valid", {31'b0, ld_valid}, {31'b0, pend_v});
        if (pend_v)
            chk(ld_data == pend_d, "R7/R8 ld_data", ld_data, pend_d);
        // Model the new request.
        word = {refmem[{e[5:2], 2'd0}], refmem[{e[5:2], 2'd1}],
                refmem[{e[5:2], 2'd2}], refmem[{e[5:2], 2'd3}]};
        pend_v = exp_req && !st;
        if (by) pend_d = {{24{refmem[e[5:0]][7]}}, refmem[e[5:0]]};
        else    pend_d = word;
        if (exp_req && st) begin
            if (by) refmem[e[5:0]] = d[7:0];
            else for (int k = 0; k < 4; k++) refmem[{e[5:2], 2'(k)}] = d[31-8*k -: 8];
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) refmem[i] = 8'(i * 37 + 5);
        for (int w = 0; w < 16; w++)
            ram[w] = {refmem[4*w], refmem[4*w+1], refmem[4*w+2], refmem[4*w+3]};
        repeat (3) @(posedge clk);
        // R9 reset state
        @(negedge clk);
        chk(ld_valid == 1'b0, "R9 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
        chk(mem_we == 4'h0 && !misalign && !mem_req, "R9 idle outputs",
            {28'b0, mem_we}, 32'h0);
        rst_n = 1'b1;
        step(0, 0, 0, 32'h0, 16'h0, 32'h0);
        // R7 word loads, R1 negative offset
        step(1, 0, 0, 32'h10, 16'h0004, 32'h0);
        step(1, 0, 0, 32'h20, 16'hFFF8, 32'h0);
        // R8 byte loads across all lanes
        for (int k = 0; k < 4; k++) step(1, 0, 1, 32'h8, 16'(k), 32'h0);
        // R2 word store, then read back
        step(1, 1, 0, 32'h0, 16'h0030, 32'hDEADBEEF);
        step(1, 0, 0, 32'h30, 16'h0, 32'h0);
        // R3 byte stores into each lane; R8 readback with sign
        for (int k = 0; k < 4; k++) step(1, 1, 1, 32'h40, 16'hFFF4 + 16'(k), 32'h0000_0080 + 32'(k * 3));
        step(1, 0, 0, 32'h34, 16'h0, 32'h0);
        for (int k = 0; k < 4; k++) step(1, 0, 1, 32'h34, 16'(k), 32'h0);
        // R4 misaligned word store and load: no write, no response
        for (int k = 1; k < 4; k++) step(1, 1, 0, 32'h4, 16'(k), 32'h12345678);
        step(1, 0, 0, 32'h6, 16'h0, 32'h0);
        step(1, 0, 0, 32'h4, 16'h0, 32'h0);
        // Back-to-back: load return coincides with store to same word
        step(1, 0, 0, 32'h18, 16'h0, 32'h0);
        step(1, 1, 1, 32'h18, 16'h2, 32'hFFFFFF7E);
        step(1, 0, 0, 32'h18, 16'h0, 32'h0);
        step(1, 1, 0, 32'h1C, 16'h0, 32'h0BADF00D);
        step(1, 0, 1, 32'h1C, 16'h1, 32'h0);
        step(1, 0, 1, 32'h1C, 16'h3, 32'h0);
        // R1 large base with wrap
        step(1, 0, 0, 32'hFFFF_FFFC, 16'h0008, 32'h0);
        step(0, 1, 0, 32'h3, 16'h0, 32'h0);
        step(0, 0, 0, 32'h0, 16'h0, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule